// File: doc/BRIEF.md
# Toggle-Flag Word Crossing

This block moves a parallel data word from a slow source clock domain into a faster destination clock domain without an asynchronous FIFO. When the source asserts its valid strobe, the word is latched into a holding register and a single-bit flag inverts. Only that flag crosses the boundary, through a two-flop synchronizer. In the destination domain, a change detector turns every transition of the synchronized flag, rising or falling, into a one-cycle load enable. That enable copies the source holding register straight into a destination register.

There is no return acknowledge. The upstream producer must respect a rate limit instead: after a strobe, the holding register may not change again until at least three destination clock edges have passed. A source clock that is clearly slower than the destination clock meets this limit even with strobes on consecutive source cycles. Each domain has its own synchronous active-high reset.

Top module: `word_toggle_cdc`

## Requirements
- R1: On a source clock edge with `src_valid` high, the holding register takes the value of `src_data`; it keeps its value on every other source edge.
- R2: The crossing flag inverts once for each source edge with `src_valid` high and holds its level otherwise.
- R3: Each accepted word produces exactly one `dst_valid` pulse, and a pulse appears only for an accepted word.
- R4: Both a rising and a falling transition of the synchronized flag cause a delivery, so consecutive words alternate the flag level and are all delivered.
- R5: `dst_valid` is high for exactly one destination cycle, and it is high in the cycle after the new word first appears on `dst_data`.
- R6: `dst_data` holds the last captured word between captures; any change of `dst_data` is followed in the next destination cycle by `dst_valid`.
- R7: Source reset clears the flag and the holding register. Destination reset clears the synchronizer stages, the change-detect history, the pipeline and `dst_data`. After both resets `dst_valid` stays low and `dst_data` reads zero until a word is sent.
- R8: Words reach `dst_data` in the order they were accepted and bit-exact, with a data width set by the `WIDTH` parameter (default 8).
- R9: Precondition: once `src_valid` has been taken, the holding register must not change again for at least three destination clock edges. Under this condition, back-to-back source strobes are all delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source synchronous reset, active high |
| src_valid | input | 1 | Word strobe; one source cycle per word |
| src_data | input | WIDTH | Word to transfer |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination synchronous reset, active high |
| dst_data | output | WIDTH | Last captured word |
| dst_valid | output | 1 | One-cycle pulse, the cycle after a new word appears |

## Verification
The bench sends runs of words on consecutive source cycles, so the flag changes both rising and falling in quick succession. A detector that caught only one edge direction would deliver half the words, and the scoreboard would report them missing. It also sends words that differ in single bits and in all bits. A capture taken from the wrong register or at the wrong moment would give corrupted or stale values. Valid timing is checked against data changes: a pulse that came with the data, or a data change with no pulse after it, is reported. Quiet periods straight after reset must show no pulse. A history flop left uninitialised would produce a spurious pulse there.

// File: rtl/word_toggle_cdc.sv
module word_toggle_cdc #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             src_clk,
  input  logic             src_rst,
  input  logic             src_valid,
  input  logic [WIDTH-1:0] src_data,
  input  logic             dst_clk,
  input  logic             dst_rst,
  output logic [WIDTH-1:0] dst_data,
  output logic             dst_valid
);

  logic [WIDTH-1:0]       hold_q;
  logic                   flag_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;
  logic                   load_q;
  logic                   flip;

  always_ff @(posedge src_clk) begin
    if (src_rst) begin
      hold_q <= '0;
      flag_q <= 1'b0;
    end else if (src_valid) begin
      hold_q <= src_data;
      flag_q <= ~flag_q;
    end
  end

  assign flip = sync_q[SYNC_STAGES-1] ^ hist_q;

  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      sync_q    <= '0;
      hist_q    <= 1'b0;
      load_q    <= 1'b0;
      dst_valid <= 1'b0;
      dst_data  <= '0;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], flag_q};
      hist_q    <= sync_q[SYNC_STAGES-1];
      load_q    <= flip;
      dst_valid <= load_q;
      if (flip) dst_data <= hold_q;
    end
  end

endmodule

// File: rtl/word_toggle_cdc_chk.sv
module word_toggle_cdc_chk #(
  parameter int WIDTH = 8
) (
  input logic             src_clk,
  input logic             src_rst,
  input logic             src_valid,
  input logic [WIDTH-1:0] src_data,
  input logic             dst_clk,
  input logic             dst_rst,
  input logic [WIDTH-1:0] dst_data,
  input logic             dst_valid,
  input logic [WIDTH-1:0] hold,
  input logic             flag,
  input logic             sync_out,
  input logic             hist
);

  assert_load_R1: assert property (@(posedge src_clk) disable iff (src_rst)
    src_valid |=> hold == $past(src_data));

  assert_keep_R1: assert property (@(posedge src_clk) disable iff (src_rst)
    !src_valid |=> $stable(hold));

  assert_toggle_R2: assert property (@(posedge src_clk) disable iff (src_rst)
    src_valid |=> flag != $past(flag));

  assert_steady_R2: assert property (@(posedge src_clk) disable iff (src_rst)
    !src_valid |=> $stable(flag));

  assert_edge_seen_R4: assert property (@(posedge dst_clk) disable iff (dst_rst)
    (sync_out != hist) |=> ##1 dst_valid);

  assert_single_pulse_R5: assert property (@(posedge dst_clk) disable iff (dst_rst)
    dst_valid |=> !dst_valid);

  assert_change_flagged_R6: assert property (@(posedge dst_clk) disable iff (dst_rst)
    !$stable(dst_data) |=> dst_valid);

  assert_src_reset_R7: assert property (@(posedge src_clk)
    src_rst |=> (flag == 1'b0 && hold == '0));

  assert_dst_reset_R7: assert property (@(posedge dst_clk)
    dst_rst |=> (!dst_valid && dst_data == '0));

endmodule

bind word_toggle_cdc word_toggle_cdc_chk #(.WIDTH(WIDTH)) chk_i (
  .src_clk   (src_clk),
  .src_rst   (src_rst),
  .src_valid (src_valid),
  .src_data  (src_data),
  .dst_clk   (dst_clk),
  .dst_rst   (dst_rst),
  .dst_data  (dst_data),
  .dst_valid (dst_valid),
  .hold      (hold_q),
  .flag      (flag_q),
  .sync_out  (sync_q[SYNC_STAGES-1]),
  .hist      (hist_q)
);

// File: tb/word_toggle_cdc_tb_top.sv
module word_toggle_cdc_tb_top;
  localparam int WIDTH      = 8;
  localparam int DST_PERIOD = 10;
  localparam int SRC_PERIOD = 37;
  localparam int WATCHDOG   = 20000;

  logic             src_clk = 1'b0;
  logic             dst_clk = 1'b0;
  logic             src_rst = 1'b1;
  logic             dst_rst = 1'b1;
  logic             src_valid = 1'b0;
  logic [WIDTH-1:0] src_data = '0;
  logic [WIDTH-1:0] dst_data;
  logic             dst_valid;

  int checks = 0;
  int failures = 0;
  int sent = 0;
  int received = 0;
  bit done = 1'b0;
  logic [WIDTH-1:0] expq[$];

  always #(SRC_PERIOD/2.0) src_clk = ~src_clk;
  always #(DST_PERIOD/2) dst_clk = ~dst_clk;

  word_toggle_cdc #(.WIDTH(WIDTH)) dut_i (
    .src_clk(src_clk), .src_rst(src_rst), .src_valid(src_valid), .src_data(src_data),
    .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_data(dst_data), .dst_valid(dst_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one strobe per source cycle, expected word pushed to the scoreboard
  task automatic send(input logic [WIDTH-1:0] w);
    @(negedge src_clk);
    src_valid = 1'b1;
    src_data  = w;
    expq.push_back(w);
    sent++;
    @(negedge src_clk);
    src_valid = 1'b0;
    src_data  = ~w;
  endtask

  task automatic send_burst(input logic [WIDTH-1:0] w);
    @(negedge src_clk);
    src_valid = 1'b1;
    src_data  = w;
    expq.push_back(w);
    sent++;
  endtask

  // monitor: pops on every pulse, watches data-versus-valid timing
  logic [WIDTH-1:0] prev_data = '0;
  bit prev_changed = 1'b0;
  bit prev_valid = 1'b0;
  bit mon_on = 1'b0;
  always @(negedge dst_clk) begin
    if (mon_on) begin
      automatic bit changed = (dst_data != prev_data);
      if (dst_valid) begin
        received++;
        check(!prev_valid, "R5 pulse width", 1, 0);
        check(!changed, "R5 data before valid", dst_data, prev_data);
        if (expq.size() == 0) begin
          check(1'b0, "R3 spurious pulse", dst_data, 0);
        end else begin
          automatic logic [WIDTH-1:0] e = expq.pop_front();
          check(dst_data == e, "R8 order/data", dst_data, e);
        end
      end
      if (prev_changed && !dst_valid)
        check(1'b0, "R6 change without valid", dst_data, prev_data);
      prev_changed = changed;
    end
    prev_data  = dst_data;
    prev_valid = dst_valid;
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge dst_clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", received, sent);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge src_clk);
    src_rst = 1'b0;
    @(negedge dst_clk);
    dst_rst = 1'b0;
    mon_on = 1'b1;
    // R7: quiet after reset, no pulse and zero data
    for (int i = 0; i < 12; i++) begin
      @(negedge dst_clk);
      check(!dst_valid, "R7 no pulse after reset", dst_valid, 0);
      check(dst_data == '0, "R7 data after reset", dst_data, 0);
    end
    // R1 R2 R4: isolated words, flag goes up then down
    send(8'hA5);
    repeat (3) @(negedge src_clk);
    send(8'h5A);
    repeat (3) @(negedge src_clk);
    send(8'hFF);
    send(8'h00);
    // R9: back-to-back strobes, both flag directions in a row
    for (int i = 0; i < 8; i++) send_burst(8'(8'h01 << i));
    for (int i = 0; i < 8; i++) send_burst(8'(8'h3C ^ (i * 17)));
    @(negedge src_clk);
    src_valid = 1'b0;
    repeat (4) @(negedge src_clk);
    send(8'h80);
    repeat (20) @(negedge dst_clk);
    // R6: data held, no pulses during idle
    for (int i = 0; i < 10; i++) begin
      @(negedge dst_clk);
      check(!dst_valid && dst_data == 8'h80, "R6 hold while idle", dst_data, 8'h80);
    end
    // R3: every word exactly once
    check(received == sent, "R3 delivery count", received, sent);
    check(expq.size() == 0, "R3 words left over", expq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule